// File: doc/BRIEF.md
# Radio Baseband Serial Register Port Master

This block is the host-side master of a three-wire serial register port that reaches the control registers of a radio baseband chip. A host asks for one register access at a time by presenting a register address, write data and a read/write flag together with a one-cycle request. The block then runs a single framed transfer on the serial pins and reports the end of it with a one-cycle completion pulse. For reads, that pulse comes with the byte returned by the baseband.

The serial clock is made by dividing the system clock by a programmable ratio, which comes out of reset as 14. Each transfer opens with the active-low select. An address phase and a data phase follow, and the select closes the transfer. A separate phase strobe tells the baseband which phase the bits on the shared data line belong to, so neither side has to count bits to find the phase boundary. The master drives the data line during the address phase and during the data phase of a write. During the data phase of a read it releases the line so the baseband can drive it.

Top module: `rfctl_serial_master`

## Requirements
- R1: After reset the select is high, the serial clock is high, the data-line drive enable is low, busy and done are low, the read-data output is zero and the divide ratio is 14.
- R2: One serial clock period lasts D system cycles, where D is the divide ratio: high for ceil(D/2) cycles and low for floor(D/2) cycles. A ratio write (`cfg_we` with `cfg_div`) takes effect only when the block is idle and no request is present in that cycle, and only when the value is 2 or more. Any other ratio write leaves the period unchanged.
- R3: The select goes low in the cycle after a request is accepted, and busy rises with it. The first falling serial clock edge comes ceil(D/2) cycles after the select falls. While the select is high, the serial clock stays high.
- R4: A transfer has exactly ADDR_W+DATA_W (default 7+8) falling and rising serial clock edges. The master changes its data bit only on falling edges. It sends the address and then the write data, each most significant bit first.
- R5: The phase strobe is 1 for each of the ADDR_W address bits and 0 for each data bit. It changes only on falling serial clock edges.
- R6: The direction output equals the request's flag (1 = read, 0 = write) from the first falling edge to the end of the transfer.
- R7: The drive enable rises at the first falling edge and stays high through the address phase. It stays high through a write's data phase and drops at the falling edge that starts a read's data phase. It is low whenever the select is high.
- R8: In a read, the master samples the data line at each rising serial clock edge of the data phase and assembles the byte most significant bit first. It presents the byte on `rd_data` in the cycle `done` is high.
- R9: The select rises ceil(D/2) cycles after the last rising edge, so it stays low for ceil(D/2)+(ADDR_W+DATA_W)*D cycles. `done` is high for exactly the first cycle the select is high again, and busy is low in that cycle.
- R10: A request made while busy is ignored and starts no further transfer. After a write completes, `rd_data` reads zero.

Parameters: `ADDR_W`, `DATA_W`, `DIV_W` (width of the ratio), `DIV_DEFAULT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a new divide ratio |
| cfg_div | input | DIV_W | Divide ratio to load |
| req | input | 1 | Start a register access (taken when idle) |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Baseband register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte returned by the last read |
| bb_sclk | output | 1 | Divided serial clock, idles high |
| bb_csn | output | 1 | Active-low select |
| bb_strobe | output | 1 | 1 = address bits, 0 = data bits |
| bb_rnw | output | 1 | Direction of the data phase |
| bb_sdio | inout | 1 | Shared serial data line |
| bb_sd_drive | output | 1 | Pad drive enable of the data line |

## Verification
The bench keeps the default widths (7-bit address, 8-bit data, 6-bit ratio) and changes the divide ratio at run time. It covers the reset value 14, the smallest ratio 2, odd ratios where the high and low halves differ, and the largest ratio 63, where the half-period arithmetic sits at the top of its width. With the 6-bit ratio field, the bench also tries ratio writes below the floor and ratio writes during a transfer, and shows at the pins that neither changes the period.

// File: rtl/rfctl_pkg.sv
package rfctl_pkg;

   // sequencer phases: idle, clock-high interval, clock-low interval
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_HIGH = 2'd1,
      SQ_LOW  = 2'd2
   } sq_state_t;

   localparam int unsigned RFCTL_DIV_FLOOR = 2;

endpackage

// File: rtl/rfctl_divcfg.sv
module rfctl_divcfg #(
   parameter int unsigned DIV_W       = 6,
   parameter int unsigned DIV_DEFAULT = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_ok,
   input  logic             cfg_we,
   input  logic [DIV_W-1:0] cfg_div,
   output logic [DIV_W-1:0] hi_init,
   output logic [DIV_W-1:0] lo_init
);
   import rfctl_pkg::*;

   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);
   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(RFCTL_DIV_FLOOR);
   localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] half_dn;
   logic [DIV_W-1:0] half_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_RST;
      end else if (load_ok && cfg_we && (cfg_div >= DIV_MIN)) begin
         div_q <= cfg_div;
      end
   end

   // floor and ceiling of half the ratio, without a carry bit
   assign half_dn = div_q >> 1;
   assign half_up = half_dn + DIV_W'(div_q[0]);
   // counters reload with length-1
   assign hi_init = half_up - ONE;
   assign lo_init = half_dn - ONE;

   // R2
   div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_q >= DIV_MIN);

endmodule

// File: rtl/rfctl_seq.sv
module rfctl_seq #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_rnw,
   input  logic [DIV_W-1:0] hi_init,
   input  logic [DIV_W-1:0] lo_init,
   output logic             busy,
   output logic             sclk,
   output logic             csn,
   output logic             strobe,
   output logic             rnw_o,
   output logic             drive,
   output logic             done,
   output logic             load,
   output logic             shift,
   output logic             sample,
   output logic             fin
);
   import rfctl_pkg::*;

   localparam int unsigned NBITS = ADDR_W + DATA_W;
   localparam int unsigned BW    = $clog2(NBITS + 1);
   localparam logic [BW-1:0] LAST_IDX = BW'(NBITS);
   localparam logic [BW-1:0] ADDR_IDX = BW'(ADDR_W);

   sq_state_t        st_q;
   logic [DIV_W-1:0] cnt_q;
   logic [BW-1:0]    bit_q;
   logic             rnw_q;
   logic             sclk_q, csn_q, strobe_q, rnwo_q, drive_q, done_q;
   logic             cnt_zero, rise_ev;

   assign cnt_zero = (cnt_q == '0);
   assign load     = (st_q == SQ_IDLE) && req;
   assign shift    = (st_q == SQ_HIGH) && cnt_zero && (bit_q != LAST_IDX);
   assign fin      = (st_q == SQ_HIGH) && cnt_zero && (bit_q == LAST_IDX);
   assign rise_ev  = (st_q == SQ_LOW) && cnt_zero;
   assign sample   = rise_ev && rnw_q && (bit_q >= ADDR_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         cnt_q    <= '0;
         bit_q    <= '0;
         rnw_q    <= 1'b0;
         sclk_q   <= 1'b1;
         csn_q    <= 1'b1;
         strobe_q <= 1'b0;
         rnwo_q   <= 1'b0;
         drive_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (req) begin
                  st_q  <= SQ_HIGH;
                  csn_q <= 1'b0;
                  cnt_q <= hi_init;
                  bit_q <= '0;
                  rnw_q <= req_rnw;
               end
            end
            SQ_HIGH: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (bit_q == LAST_IDX) begin
                  st_q    <= SQ_IDLE;
                  csn_q   <= 1'b1;
                  drive_q <= 1'b0;
                  done_q  <= 1'b1;
               end else begin
                  // falling edge: launch the next bit and its qualifiers
                  st_q     <= SQ_LOW;
                  sclk_q   <= 1'b0;
                  strobe_q <= (bit_q < ADDR_IDX);
                  rnwo_q   <= rnw_q;
                  drive_q  <= (bit_q < ADDR_IDX) || !rnw_q;
                  cnt_q    <= lo_init;
               end
            end
            SQ_LOW: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  // rising edge: the far end samples here
                  st_q   <= SQ_HIGH;
                  sclk_q <= 1'b1;
                  bit_q  <= bit_q + 1'b1;
                  cnt_q  <= hi_init;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != SQ_IDLE);
   assign sclk   = sclk_q;
   assign csn    = csn_q;
   assign strobe = strobe_q;
   assign rnw_o  = rnwo_q;
   assign drive  = drive_q;
   assign done   = done_q;

   // R7
   drive_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_q |-> !drive_q);
   // R7
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn_q && rnwo_q && !strobe_q) |-> !drive_q);
   // R5
   strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn_q && $past(!csn_q) && !$fell(sclk_q)) |-> ($stable(strobe_q) && $stable(rnwo_q)));
   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_q |-> sclk_q);
   // R9
   done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($rose(csn_q) && !busy));
   // R10
   start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $fell(csn_q));

endmodule

// File: rtl/rfctl_shift.sv
module rfctl_shift #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              sample,
   input  logic              commit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sd_in,
   output logic              sd_out,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned NBITS = ADDR_W + DATA_W;

   logic [NBITS-1:0]  tx_q;
   logic              sd_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rd_q;

   // outgoing frame: address then data, most significant bit first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         sd_q <= 1'b0;
      end else if (load) begin
         tx_q <= {addr, wdata};
      end else if (shift) begin
         sd_q <= tx_q[NBITS-1];
         tx_q <= {tx_q[NBITS-2:0], 1'b0};
      end
   end

   // incoming byte, cleared per transfer so writes return zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
         rd_q <= '0;
      end else begin
         if (load) begin
            rx_q <= '0;
         end else if (sample) begin
            rx_q <= {rx_q[DATA_W-2:0], sd_in};
         end
         if (commit) begin
            rd_q <= rx_q;
         end
      end
   end

   assign sd_out  = sd_q;
   assign rd_data = rd_q;

   // R4
   sd_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd_q) |-> $past(shift));
   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_q) |-> $past(commit));

endmodule

// File: rtl/rfctl_serial_master.sv
module rfctl_serial_master #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 6,
   parameter int unsigned DIV_DEFAULT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              req,
   input  logic              req_rnw,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              bb_sclk,
   output logic              bb_csn,
   output logic              bb_strobe,
   output logic              bb_rnw,
   inout  wire               bb_sdio,
   output logic              bb_sd_drive
);
   import rfctl_pkg::*;

   // elaboration-time parameter checks
   if (ADDR_W < 1) begin : g_bad_addr
      $error("rfctl_serial_master: ADDR_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("rfctl_serial_master: DATA_W must be at least 2");
   end
   if ((DIV_DEFAULT < RFCTL_DIV_FLOOR) || (DIV_DEFAULT >= (1 << DIV_W))) begin : g_bad_div
      $error("rfctl_serial_master: DIV_DEFAULT outside 2 .. 2**DIV_W-1");
   end

   logic [DIV_W-1:0] hi_init, lo_init;
   logic             load, shift, sample, fin;
   logic             sd_out, sd_in, drive;

   rfctl_divcfg #(.DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_ok (!busy && !req),
      .cfg_we  (cfg_we),
      .cfg_div (cfg_div),
      .hi_init (hi_init),
      .lo_init (lo_init)
   );

   rfctl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_rnw (req_rnw),
      .hi_init (hi_init),
      .lo_init (lo_init),
      .busy    (busy),
      .sclk    (bb_sclk),
      .csn     (bb_csn),
      .strobe  (bb_strobe),
      .rnw_o   (bb_rnw),
      .drive   (drive),
      .done    (done),
      .load    (load),
      .shift   (shift),
      .sample  (sample),
      .fin     (fin)
   );

   rfctl_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (shift),
      .sample  (sample),
      .commit  (fin),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .sd_in   (sd_in),
      .sd_out  (sd_out),
      .rd_data (rd_data)
   );

   assign bb_sdio     = drive ? sd_out : 1'bz;
   assign sd_in       = bb_sdio;
   assign bb_sd_drive = drive;

endmodule

// File: tb/rfctl_serial_master_test.sv
module rfctl_serial_master_test;
   localparam int CLK_NS = 10;
   localparam int AW = 7;
   localparam int DW = 8;
   localparam int NB = AW + DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [5:0] cfg_div = '0;
   logic req = 1'b0;
   logic req_rnw = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic busy, done, sclk, csn, strobe, rnw, drive;
   logic [DW-1:0] rd_data;
   wire sdio;

   int checks = 0;
   int errors = 0;
   int model_div = 14;

   // baseband model: drives only in the data phase of a read
   logic [DW-1:0] slv_reg = '0;
   logic slv_oe;
   assign slv_oe = !csn && rnw && !strobe && !drive;
   assign sdio = slv_oe ? slv_reg[DW-1] : 1'bz;

   rfctl_serial_master uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
      .req(req), .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data),
      .bb_sclk(sclk), .bb_csn(csn), .bb_strobe(strobe), .bb_rnw(rnw),
      .bb_sdio(sdio), .bb_sd_drive(drive)
   );

   always #(CLK_NS/2) clk = ~clk;

   // pin monitor, sampled mid-cycle
   int cs_len, run, falls, rises, lead, tail;
   int hi_min, hi_max, lo_min, lo_max;
   int bits, strb, drv, rnwv;
   logic cur_lvl, prev_csn = 1'b1;

   always @(negedge clk) begin
      if (!csn) begin
         if (prev_csn) begin
            cs_len = 0; run = 0; falls = 0; rises = 0; lead = -1; tail = -1;
            hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
            bits = 0; strb = 0; drv = 0; rnwv = 0; cur_lvl = 1'b1;
         end
         cs_len++;
         if (sclk != cur_lvl) begin
            if (cur_lvl) begin
               if (lead < 0) lead = run;
               else begin
                  if (run < hi_min) hi_min = run;
                  if (run > hi_max) hi_max = run;
               end
               falls++;
            end else begin
               if (run < lo_min) lo_min = run;
               if (run > lo_max) lo_max = run;
               if (rises < NB) begin
                  bits[NB-1-rises] = sdio;
                  strb[NB-1-rises] = strobe;
                  drv[NB-1-rises]  = drive;
                  rnwv[NB-1-rises] = rnw;
               end
               if (rnw && !strobe) slv_reg = {slv_reg[DW-2:0], 1'b0};
               rises++;
            end
            cur_lvl = sclk;
            run = 1;
         end else begin
            run++;
         end
      end else if (!prev_csn) begin
         tail = run;
      end
      prev_csn = csn;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic int hi_of(input int d); return (d + 1) / 2; endfunction
   function automatic int lo_of(input int d); return d / 2; endfunction
   function automatic int frame_bits(input int a, input int w); return (a << DW) | w; endfunction
   function automatic int strobe_pat(); return ((1 << AW) - 1) << DW; endfunction
   function automatic int drive_pat(input bit rd);
      return rd ? strobe_pat() : ((1 << NB) - 1);
   endfunction

   task automatic set_div(input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_div = 6'(v);
      @(negedge clk);
      cfg_we = 1'b0;
      if (v >= 2) model_div = v;
   endtask

   // one access; poke_req / poke_cfg stimulate while busy
   task automatic txn(input bit rd, input int a, input int w, input int rpat,
                      input bit poke_req, input bit poke_cfg);
      int d, waited;
      d = model_div;
      slv_reg = 8'(rpat);
      @(negedge clk);
      req = 1'b1; req_rnw = rd; req_addr = 7'(a); req_wdata = 8'(w);
      @(negedge clk);
      req = 1'b0;
      // R3: select low and busy high one cycle after acceptance
      chk(!csn && busy, "R3 select/busy after accept", {30'd0, csn, busy}, 1);
      if (poke_req) begin
         @(negedge clk);
         req = 1'b1; req_rnw = ~rd; req_addr = 7'(~a);
         @(negedge clk);
         req = 1'b0;
      end
      if (poke_cfg) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_div = 6'd3;
         @(negedge clk);
         cfg_we = 1'b0;
      end
      waited = 0;
      while (!done && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      // R9: done coincides with select high, busy low
      chk(done && csn && !busy, "R9 done with select high", {29'd0, done, csn, busy}, 6);
      // R8 / R10: read byte or zero for a write
      chk(rd_data == (rd ? 8'(rpat) : 8'd0), rd ? "R8 read data" : "R10 write returns zero",
          int'(rd_data), rd ? (rpat & 8'hff) : 0);
      @(negedge clk);
      chk(!done, "R9 done single cycle", int'(done), 0);
      chk(lead == hi_of(d), "R3 select lead", lead, hi_of(d));
      chk(falls == NB && rises == NB, "R4 edge count", falls * 100 + rises, NB * 101);
      chk(hi_min == hi_of(d) && hi_max == hi_of(d), "R2 high half", hi_max, hi_of(d));
      chk(lo_min == lo_of(d) && lo_max == lo_of(d), "R2 low half", lo_max, lo_of(d));
      chk(tail == hi_of(d), "R9 select tail", tail, hi_of(d));
      chk(cs_len == hi_of(d) + NB * d, "R9 select length", cs_len, hi_of(d) + NB * d);
      chk(bits == frame_bits(a, rd ? rpat : w), "R4 serial bits", bits, frame_bits(a, rd ? rpat : w));
      chk(strb == strobe_pat(), "R5 phase strobe", strb, strobe_pat());
      chk(rnwv == (rd ? ((1 << NB) - 1) : 0), "R6 direction", rnwv, rd ? ((1 << NB) - 1) : 0);
      chk(drv == drive_pat(rd), "R7 drive enable", drv, drive_pat(rd));
      if (poke_req) begin
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(csn && !busy, "R10 request while busy ignored", {30'd0, csn, busy}, 2);
         end
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(csn && sclk && !drive && !busy && !done, "R1 reset pins",
          {27'd0, csn, sclk, drive, busy, done}, 24);
      chk(rd_data == 8'd0, "R1 reset read data", int'(rd_data), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // default ratio 14 (R1, R2)
      txn(1'b0, 7'h55, 8'hA5, 0, 1'b0, 1'b0);
      txn(1'b1, 7'h2A, 0, 8'h96, 1'b0, 1'b0);
      // odd ratio
      set_div(5);
      txn(1'b0, 7'h01, 8'h80, 0, 1'b0, 1'b0);
      txn(1'b1, 7'h7F, 0, 8'h01, 1'b0, 1'b0);
      // floor ratio, then rejected writes below it (R2)
      set_div(2);
      txn(1'b1, 7'h40, 0, 8'hFF, 1'b0, 1'b0);
      set_div(1);
      set_div(0);
      txn(1'b0, 7'h00, 8'h3C, 0, 1'b0, 1'b0);
      // ratio write during a transfer is ignored (R2), request while busy ignored (R10)
      set_div(9);
      txn(1'b1, 7'h33, 0, 8'h5A, 1'b1, 1'b1);
      txn(1'b0, 7'h4C, 8'hC3, 0, 1'b1, 1'b0);
      // top of the ratio range
      set_div(63);
      txn(1'b1, 7'h15, 0, 8'hA0, 1'b0, 1'b0);
      // constrained random
      for (int k = 0; k < 20; k++) begin
         set_div(2 + int'($urandom_range(0, 18)));
         txn(1'($urandom_range(0, 1)), int'($urandom_range(0, 127)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 1'b0, 1'b0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule